// File: doc/BRIEF.md
# Page Table Walker with Protection

This block turns a logical address into a physical address by reading one entry from a single-level page table in memory. Software first loads a table base and a table length with a configuration write. Each request carries a logical address and an access kind. The low bits of the address are the byte offset inside the page. The remaining upper bits select the page. The walker checks the page against the length, reads the entry at base plus page through a simple request/response memory port, then checks the entry's present bit and permission bits.

The result comes back as a one-cycle done strobe. With it comes either a physical address, which is the frame from the entry placed above the unchanged offset, or a two-bit fault code. Only one walk runs at a time, and the requester waits while the walker is busy. With the default widths, page 0 mapped to frame 5 turns logical address 3 into physical address 23.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, done, fault, paddr and mem_req are all 0 and req_ready is 1. The stored table length is 0, so every page is out of range until a configuration write.
- R2: The page number is req_addr[LA_W-1:OFF_W] and the offset is req_addr[OFF_W-1:0]. On success, paddr = {frame, offset}.
- R3: For an in-range page, exactly one mem_req pulse of one cycle is issued, with mem_addr = (base + page) mod 2^MEM_AW.
- R4: A page number equal to or greater than the stored length gives fault 2'b01 and paddr 0. No mem_req is issued, and done is high in the cycle right after acceptance.
- R5: The entry layout is {frame, valid (bit 3), read (bit 2), write (bit 1), execute (bit 0)}. An entry with valid = 0 gives fault 2'b10 and paddr 0, whatever its permission bits are.
- R6: The access kind is req_kind: 2'b00 is a read and needs the read bit, 2'b01 is a write and needs the write bit, 2'b10 or 2'b11 is a fetch and needs the execute bit. A valid entry that lacks the needed bit gives fault 2'b11 and paddr 0.
- R7: done is high for exactly one cycle per walk. Whenever done is low, fault and paddr are 0.
- R8: busy rises in the cycle after acceptance and stays high up to and including the done cycle. req_ready is the inverse of busy. A request held during busy starts no new walk.
- R9: A configuration write loads base and length. A length of 0 rejects page 0, and a length of 2^PAGE_W admits every page.
- R10: done rises in the cycle after the cycle in which mem_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the table base and length |
| cfg_base | input | MEM_AW | Word address of table entry 0 |
| cfg_len | input | PAGE_W+1 | Number of legal pages |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_addr | input | PAGE_W+OFF_W | Logical address |
| req_kind | input | 2 | Access kind: read, write or fetch |
| mem_req | output | 1 | Table read request, one cycle |
| mem_addr | output | MEM_AW | Word address of the entry |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | FRAME_W+4 | Table entry |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result strobe |
| fault | output | 2 | 00 ok, 01 range, 10 absent, 11 protection |
| paddr | output | FRAME_W+OFF_W | Physical address |

## Verification
The bench goes after these corner cases:

- **Length boundary.** It drives the last legal page and the first illegal page. An off-by-one compare would translate the first illegal page, or reject the last legal one.
- **Base near the top of table space.** A base close to the top makes the entry address wrap. A walker that widened the sum or used the wrong operand would read the wrong entry.
- **Invalid entries with every permission set.** These show whether the present check takes priority over the permission check.
- **Held and stalled requests.** A request is held through a whole walk, and memory latency is varied. A walker that accepted while busy, or timed done from the request instead of the response, would produce extra reads or early strobes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_RANGE  = 2'b01,
        FLT_ABSENT = 2'b10,
        FLT_PROT   = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_XALT  = 2'b11
    } access_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ISSUE,
        W_WAIT,
        W_DONE
    } walk_e;

    localparam int FLAG_BITS = 4;
    localparam int BIT_X = 0;
    localparam int BIT_W = 1;
    localparam int BIT_R = 2;
    localparam int BIT_V = 3;
endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int FRAME_W = 3
) (
    input  logic [FRAME_W+FLAG_BITS-1:0] entry_i,
    input  access_e                      kind_i,
    output fault_e                       fault_o,
    output logic [FRAME_W-1:0]           frame_o
);
    logic need_ok;

    always_comb begin
        frame_o = entry_i[FRAME_W+FLAG_BITS-1:FLAG_BITS];
        unique case (kind_i)
            ACC_LOAD:  need_ok = entry_i[BIT_R];
            ACC_STORE: need_ok = entry_i[BIT_W];
            default:   need_ok = entry_i[BIT_X];
        endcase
        if (!entry_i[BIT_V]) begin
            fault_o = FLT_ABSENT;
        end else if (!need_ok) begin
            fault_o = FLT_PROT;
        end else begin
            fault_o = FLT_NONE;
        end
    end
endmodule

// File: rtl/ptw_compose.sv
module ptw_compose
    import ptw_pkg::*;
#(
    parameter int FRAME_W = 3,
    parameter int OFF_W   = 2
) (
    input  logic [FRAME_W-1:0]       frame_i,
    input  logic [OFF_W-1:0]         off_i,
    input  fault_e                   fault_i,
    output logic [FRAME_W+OFF_W-1:0] paddr_o
);
    always_comb begin
        paddr_o = (fault_i == FLT_NONE) ? {frame_i, off_i} : '0;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int PAGE_W  = 4,
    parameter int OFF_W   = 2,
    parameter int FRAME_W = 3,
    parameter int MEM_AW  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [MEM_AW-1:0]             cfg_base,
    input  logic [PAGE_W:0]               cfg_len,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [PAGE_W+OFF_W-1:0]       req_addr,
    input  logic [1:0]                    req_kind,
    output logic                          mem_req,
    output logic [MEM_AW-1:0]             mem_addr,
    input  logic                          mem_rvalid,
    input  logic [FRAME_W+FLAG_BITS-1:0]  mem_rdata,
    output logic                          busy,
    output logic                          done,
    output logic [1:0]                    fault,
    output logic [FRAME_W+OFF_W-1:0]      paddr
);
    localparam int LA_W = PAGE_W + OFF_W;
    localparam int PA_W = FRAME_W + OFF_W;

    typedef struct packed {
        walk_e             st;
        logic [MEM_AW-1:0] base;
        logic [PAGE_W:0]   len;
        logic [MEM_AW-1:0] eaddr;
        logic [OFF_W-1:0]  off;
        access_e           kind;
        logic              done;
        fault_e            fault;
        logic [PA_W-1:0]   paddr;
    } regs_t;

    regs_t r_q, r_d;

    logic [PAGE_W-1:0]  page_w;
    fault_e             chk_fault;
    logic [FRAME_W-1:0] chk_frame;
    logic [PA_W-1:0]    cmp_paddr;

    assign page_w = req_addr[LA_W-1:OFF_W];

    ptw_entry_check #(.FRAME_W(FRAME_W)) u_check (
        .entry_i (mem_rdata),
        .kind_i  (r_q.kind),
        .fault_o (chk_fault),
        .frame_o (chk_frame)
    );

    ptw_compose #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_compose (
        .frame_i (chk_frame),
        .off_i   (r_q.off),
        .fault_i (chk_fault),
        .paddr_o (cmp_paddr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = FLT_NONE;
        r_d.paddr = '0;
        if (cfg_we) begin
            r_d.base = cfg_base;
            r_d.len  = cfg_len;
        end
        unique case (r_q.st)
            W_IDLE: begin
                if (req_valid) begin
                    r_d.off   = req_addr[OFF_W-1:0];
                    r_d.kind  = access_e'(req_kind);
                    r_d.eaddr = r_q.base + MEM_AW'(page_w);
                    if ({1'b0, page_w} >= r_q.len) begin
                        r_d.st    = W_DONE;
                        r_d.done  = 1'b1;
                        r_d.fault = FLT_RANGE;
                    end else begin
                        r_d.st = W_ISSUE;
                    end
                end
            end
            W_ISSUE: r_d.st = W_WAIT;
            W_WAIT: begin
                if (mem_rvalid) begin
                    r_d.st    = W_DONE;
                    r_d.done  = 1'b1;
                    r_d.fault = chk_fault;
                    r_d.paddr = cmp_paddr;
                end
            end
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: W_IDLE, base: '0, len: '0, eaddr: '0, off: '0,
                     kind: ACC_LOAD, done: 1'b0, fault: FLT_NONE, paddr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != W_IDLE);
    assign req_ready = !busy;
    assign mem_req   = (r_q.st == W_ISSUE);
    assign mem_addr  = r_q.eaddr;
    assign done      = r_q.done;
    assign fault     = r_q.fault;
    assign paddr     = r_q.paddr;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (fault == 2'b00 && paddr == '0)); // R7
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy); // R8
    AST_RESP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && busy && !mem_req && !done) |=> done); // R10
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
    localparam int PAGE_W  = 4;
    localparam int OFF_W   = 2;
    localparam int FRAME_W = 3;
    localparam int MEM_AW  = 8;
    localparam int EW      = FRAME_W + 4;
    localparam int PA_W    = FRAME_W + OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [MEM_AW-1:0] cfg_base = '0;
    logic [PAGE_W:0] cfg_len = '0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [PAGE_W+OFF_W-1:0] req_addr = '0;
    logic [1:0] req_kind = '0;
    logic mem_req;
    logic [MEM_AW-1:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [EW-1:0] mem_rdata = '0;
    logic busy, done;
    logic [1:0] fault;
    logic [PA_W-1:0] paddr;

    int checks = 0;
    int errors = 0;
    logic [EW-1:0] ptab [0:(1<<MEM_AW)-1];
    logic [MEM_AW-1:0] base_m = '0;
    int len_m = 0;
    int lat_cfg = 1;
    int pend = 0;
    logic [MEM_AW-1:0] hold = '0;
    int mem_cnt = 0;
    logic [MEM_AW-1:0] last_maddr = '0;
    bit finished = 0;

    always #2 clk = ~clk;

    pt_walker #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault), .paddr(paddr)
    );

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            mem_cnt++;
            last_maddr = mem_addr;
            pend <= lat_cfg;
            hold <= mem_addr;
        end else if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= ptab[hold];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [PA_W+1:0] model(input logic [EW-1:0] e, input logic [1:0] k);
        logic need;
        need = (k == 2'b00) ? e[2] : (k == 2'b01) ? e[1] : e[0];
        if (!e[3]) return {2'b10, {PA_W{1'b0}}};
        if (!need) return {2'b11, {PA_W{1'b0}}};
        return {2'b00, e[EW-1:4], {OFF_W{1'b0}}};
    endfunction

    task automatic configure(input logic [MEM_AW-1:0] b, input int l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_base = b; cfg_len = (PAGE_W+1)'(l);
        @(negedge clk);
        cfg_we = 1'b0;
        base_m = b; len_m = l;
    endtask

    task automatic run(input int pg, input int off, input logic [1:0] k, input bit hold_req);
        int cyc, rv_cyc, start_cnt, exp_f, exp_pa;
        logic [MEM_AW-1:0] ea;
        logic [PA_W+1:0] m;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr = (PAGE_W+OFF_W)'((pg << OFF_W) | off);
        req_kind = k;
        start_cnt = mem_cnt;
        ea = base_m + MEM_AW'(pg);
        @(negedge clk);
        if (!hold_req) req_valid = 1'b0;
        chk(busy && !req_ready, "R8", "busy after accept", busy, 1);
        cyc = 1; rv_cyc = -10;
        while (!done && cyc < 50) begin
            chk(fault == 2'b00 && paddr == '0, "R7", "quiet before done", fault, 0);
            if (mem_rvalid) rv_cyc = cyc;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(done, "R10", "done seen", done, 1);
        chk(busy, "R8", "busy in done cycle", busy, 1);
        if (pg >= len_m) begin
            exp_f = 1; exp_pa = 0;
            chk(cyc == 1, "R4", "done latency", cyc, 1);
            chk(mem_cnt == start_cnt, "R4", "no table read", mem_cnt - start_cnt, 0);
        end else begin
            m = model(ptab[ea], k);
            exp_f = int'(m[PA_W+1:PA_W]);
            exp_pa = int'(m[PA_W-1:0]) | ((exp_f == 0) ? off : 0);
            chk(mem_cnt == start_cnt + 1, "R3", "one table read", mem_cnt - start_cnt, 1);
            chk(last_maddr == ea, "R3", "entry address", last_maddr, ea);
            chk(cyc == rv_cyc + 1, "R10", "done after response", cyc, rv_cyc + 1);
        end
        chk(fault == exp_f[1:0], (exp_f == 2) ? "R5" : (exp_f == 3) ? "R6" : "R2", "fault code", fault, exp_f);
        chk(paddr == exp_pa[PA_W-1:0], "R2", "physical address", paddr, exp_pa);
        @(negedge clk);
        chk(!done && fault == 2'b00 && paddr == '0, "R7", "single pulse", done, 0);
        chk(mem_cnt == start_cnt + ((pg >= len_m) ? 0 : 1), "R8", "no walk from held request", mem_cnt - start_cnt, (pg >= len_m) ? 0 : 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << MEM_AW); i++) ptab[i] = EW'($urandom);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !done && fault == 0 && paddr == 0 && !mem_req && req_ready, "R1", "reset outputs", busy, 0);
        run(0, 1, 2'b00, 0); // R1: length 0 after reset
        // R2 worked example: page 0 to frame 5, address 3 to 23
        ptab[8'h10] = {3'd5, 4'b1111};
        configure(8'h10, 16);
        run(0, 3, 2'b00, 0);
        chk(paddr == 0, "R2", "idle paddr", paddr, 0);
        // R4 / R9 boundary of the length
        configure(8'h20, 4);
        ptab[8'h23] = {3'd6, 4'b1100};
        run(3, 2, 2'b00, 0);
        run(4, 2, 2'b00, 0);
        configure(8'h20, 0);
        run(0, 0, 2'b00, 0); // R9
        configure(8'h20, 16);
        ptab[8'h2F] = {3'd7, 4'b1111};
        run(15, 3, 2'b10, 0); // R9 full length
        // R5 invalid with all permissions
        ptab[8'h21] = {3'd2, 4'b0111};
        run(1, 1, 2'b00, 0);
        // R6 protection per kind
        ptab[8'h22] = {3'd3, 4'b1100};
        run(2, 0, 2'b01, 0);
        run(2, 0, 2'b10, 0);
        ptab[8'h24] = {3'd4, 4'b1011};
        run(4, 1, 2'b00, 0);
        run(4, 1, 2'b11, 0);
        // R3 wrap of the entry address
        configure(8'hFE, 16);
        ptab[8'h03] = {3'd1, 4'b1110};
        run(5, 2, 2'b01, 0);
        // R8 request held through a whole walk, slow memory
        lat_cfg = 3;
        run(5, 1, 2'b00, 1);
        run(20 % 16, 0, 2'b00, 1);
        // random mix
        for (int it = 0; it < 300; it++) begin
            if (($urandom % 10) == 0) configure(MEM_AW'($urandom), int'($urandom % 17));
            lat_cfg = 1 + int'($urandom % 3);
            run(int'($urandom % 16), int'($urandom % 4), 2'($urandom), 1'($urandom % 4 == 0));
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule